// File: doc/BRIEF.md
# Register-List Stack Frame Sequencer

This block builds and tears down a stack frame over several cycles, one memory word at a time. A 12-bit register list selects any subset of a bank of twelve registers, numbered 20 to 31. A 5-bit frame-size value reserves or releases extra stack space in units of one 32-bit word. In build mode the selected registers are pushed onto a stack that grows downward, and then the extra space is reserved. In teardown mode the extra space is released first, the selected registers are popped back, and a jump to the value held in a named register can be requested.

The block connects to three things. The first is a single-word memory port that holds each access until a ready pulse arrives. The second is a port into the general register file, with a combinational read and a write strobe. The third is the stack pointer, loaded when a sequence starts and returned when it finishes. Registers are stored so that lower numbers sit at higher addresses. Because of this, a teardown with the same list and frame size restores exactly what the build saved.

Top module: `frame_seq`

## Requirements
- R1: The list is `{list_hi_i, list_lo_i}`, with `list_hi_i` as bit 11. List bit k selects register 20+k.
- R2: In build mode (`mode_i`=0), the selected registers are visited in ascending number. For each one, the stack pointer is decreased by 4 and the register word is written at the new stack pointer.
- R3: In build mode, after the last push, the stack pointer is decreased by 4 times the frame size. The final value is the start value minus 4×(selected count + frame size).
- R4: In teardown mode (`mode_i`=1), the stack pointer is first increased by 4 times the frame size. The selected registers are then visited in descending number: each is loaded from the stack pointer and written to its register, and the stack pointer is then increased by 4.
- R5: A teardown with the same list and frame size, started from the pointer a build returned, restores every selected register and returns the pointer to its value before the build.
- R6: At completion of a teardown whose jump field `jreg_i` is nonzero, `jump_o` is high together with `done_o`, and `jump_target_o` carries the value of that register after the pops. A zero field, or build mode, gives no jump.
- R7: A register whose list bit is clear takes no cycle and causes no memory access, and its register is not written.
- R8: Each access keeps `mem_req_o`, `mem_addr_o` and `mem_we_o` steady until `mem_rdy_i`. With w wait cycles per access, `done_o` rises 1 + (frame size ≠ 0) + count×(w+1) cycles after the start edge.
- R9: `done_o` is a one-cycle pulse, and `sp_o` holds the final stack pointer in that cycle.
- R10: An empty list with a zero frame size gives `done_o` one cycle after the start edge, with `sp_o` equal to `sp_i`.
- R11: A `start_i` pulse during a sequence is ignored. The running sequence keeps its timing and results.
- R12: After reset, `done_o`, `jump_o`, `mem_req_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence (taken only when idle) |
| mode_i | input | 1 | 0 = build frame, 1 = tear down frame |
| list_hi_i | input | 1 | Top bit of the register list |
| list_lo_i | input | 11 | Lower bits of the register list |
| frame_imm_i | input | 5 | Extra frame size in words |
| jreg_i | input | 5 | Jump register number for teardown, 0 = none |
| sp_i | input | 32 | Stack pointer at start |
| sp_o | output | 32 | Stack pointer, final when done_o is high |
| done_o | output | 1 | One-cycle completion pulse |
| jump_o | output | 1 | Jump request, with done_o |
| jump_target_o | output | 32 | Jump address |
| mem_req_o | output | 1 | Memory access pending |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_rdy_i |
| mem_rdy_i | input | 1 | Access completes this cycle |
| rf_idx_o | output | 5 | Register file index for read and write |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write strobe |
| rf_wdata_o | output | 32 | Register file write data |

## Verification
Every one of the 4096 lists is first built and then torn down. Each pair uses a frame size that walks all 32 values, so sparse, dense, empty and single-bit lists all appear under both adjustments. The logged addresses and register numbers separate ascending from descending order and pre-adjustment from post-adjustment. Restoring into a scrambled bank separates registers that were written from registers that should have been left alone. Directed runs then add wait states, a start pulse while busy, and jump fields naming a restored register, an untouched register and register zero. These show whether the jump reads the value after the pops and whether it is gated by mode.

// File: rtl/frame_seq_pkg.sv
`timescale 1ns/1ps
package frame_seq_pkg;

  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RELEASE,
    ST_XFER,
    ST_RESERVE,
    ST_FIN
  } seq_state_t;

  typedef enum logic [2:0] {
    SP_HOLD,
    SP_LOAD,
    SP_STEP_DN,
    SP_STEP_UP,
    SP_FRAME_DN,
    SP_FRAME_UP
  } sp_op_t;

  // bytes covered by a frame-size value given in words
  function automatic int unsigned frame_bytes(input int unsigned words);
    return words * WORD_BYTES;
  endfunction

  // register number selected by a list bit
  function automatic int unsigned bank_reg(input int unsigned bit_pos,
                                           input int unsigned base);
    return base + bit_pos;
  endfunction

endpackage

// File: rtl/frame_seq_pick.sv
`timescale 1ns/1ps
module frame_seq_pick #(
  parameter int unsigned NSLOT = 12,
  localparam int unsigned IW   = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] mask,
  input  logic             desc,
  output logic             any,
  output logic [IW-1:0]    pos
);

  always_comb begin
    any = |mask;
    pos = '0;
    if (desc) begin
      for (int i = 0; i < NSLOT; i++)
        if (mask[i]) pos = IW'(i);
    end else begin
      for (int i = NSLOT - 1; i >= 0; i--)
        if (mask[i]) pos = IW'(i);
    end
  end

  // R7: the chosen slot is always a selected one
  a_r7_pick_is_selected: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> mask[pos]);

  // R2: ascending walk never skips a lower selected slot
  a_r2_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !desc) |-> ((mask & ((NSLOT'(1) << pos) - NSLOT'(1))) == '0));

  // R4: descending walk never skips a higher selected slot
  a_r4_highest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (any && desc) |-> ((mask >> pos) == NSLOT'(1)));

endmodule

// File: rtl/frame_seq_sp.sv
`timescale 1ns/1ps
module frame_seq_sp
  import frame_seq_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned IMMW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  sp_op_t          op,
  input  logic [AW-1:0]   sp_in,
  input  logic [IMMW-1:0] imm,
  output logic [AW-1:0]   sp_q,
  output logic [AW-1:0]   sp_dn
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] frame_amt;

  assign frame_amt = AW'(frame_bytes(int'(imm)));
  assign sp_dn     = sp_q - STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else begin
      case (op)
        SP_LOAD:     sp_q <= sp_in;
        SP_STEP_DN:  sp_q <= sp_dn;
        SP_STEP_UP:  sp_q <= sp_q + STEP;
        SP_FRAME_DN: sp_q <= sp_q - frame_amt;
        SP_FRAME_UP: sp_q <= sp_q + frame_amt;
        default:     sp_q <= sp_q;
      endcase
    end
  end

  // R9: the pointer is frozen whenever no update is commanded
  a_r9_sp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SP_HOLD) |=> $stable(sp_q));

endmodule

// File: rtl/frame_seq.sv
`timescale 1ns/1ps
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int unsigned NREG     = 12,
  parameter int unsigned BASE_REG = 20,
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned IMMW     = 5,
  parameter int unsigned RIDX_W   = 5,
  localparam int unsigned LO_W    = NREG - 1,
  localparam int unsigned PW      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              list_hi_i,
  input  logic [LO_W-1:0]   list_lo_i,
  input  logic [IMMW-1:0]   frame_imm_i,
  input  logic [RIDX_W-1:0] jreg_i,
  input  logic [AW-1:0]     sp_i,
  output logic [AW-1:0]     sp_o,
  output logic              done_o,
  output logic              jump_o,
  output logic [DW-1:0]     jump_target_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic [RIDX_W-1:0] rf_idx_o,
  input  logic [DW-1:0]     rf_rdata_i,
  output logic              rf_we_o,
  output logic [DW-1:0]     rf_wdata_o
);

  seq_state_t        state_q, state_d;
  logic              teardown_q;
  logic [NREG-1:0]   pend_q, pend_nxt;
  logic [IMMW-1:0]   imm_q;
  logic [RIDX_W-1:0] jreg_q;
  sp_op_t            sp_op;
  logic [AW-1:0]     sp_q, sp_dn;

  // named internal events
  logic [NREG-1:0]   list_full;
  logic              accept;
  logic              xfer_fire;
  logic              xfer_last;
  logic              pick_any;
  logic [PW-1:0]     pick_pos;
  logic [RIDX_W-1:0] cur_reg;

  assign list_full = {list_hi_i, list_lo_i};
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign xfer_fire = (state_q == ST_XFER) && mem_rdy_i;
  assign pend_nxt  = pend_q & ~(NREG'(1) << pick_pos);
  assign xfer_last = xfer_fire && (pend_nxt == '0);
  assign cur_reg   = RIDX_W'(bank_reg(int'(pick_pos), BASE_REG));

  frame_seq_pick #(.NSLOT(NREG)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .mask  (pend_q),
    .desc  (teardown_q),
    .any   (pick_any),
    .pos   (pick_pos)
  );

  frame_seq_sp #(.AW(AW), .IMMW(IMMW)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (sp_op),
    .sp_in (sp_i),
    .imm   (imm_q),
    .sp_q  (sp_q),
    .sp_dn (sp_dn)
  );

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (mode_i && frame_imm_i != '0)       state_d = ST_RELEASE;
          else if (list_full != '0)             state_d = ST_XFER;
          else if (!mode_i && frame_imm_i != '0) state_d = ST_RESERVE;
          else                                  state_d = ST_FIN;
        end
      end
      ST_RELEASE: state_d = (pend_q != '0) ? ST_XFER : ST_FIN;
      ST_XFER: begin
        if (xfer_last)
          state_d = (!teardown_q && imm_q != '0) ? ST_RESERVE : ST_FIN;
      end
      ST_RESERVE: state_d = ST_FIN;
      default:    state_d = ST_IDLE;
    endcase
  end

  // stack pointer command
  always_comb begin
    sp_op = SP_HOLD;
    case (state_q)
      ST_IDLE:    if (start_i) sp_op = SP_LOAD;
      ST_RELEASE: sp_op = SP_FRAME_UP;
      ST_XFER:    if (mem_rdy_i) sp_op = teardown_q ? SP_STEP_UP : SP_STEP_DN;
      ST_RESERVE: sp_op = SP_FRAME_DN;
      default:    sp_op = SP_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      teardown_q <= 1'b0;
      pend_q     <= '0;
      imm_q      <= '0;
      jreg_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        teardown_q <= mode_i;
        pend_q     <= list_full;
        imm_q      <= frame_imm_i;
        jreg_q     <= jreg_i;
      end else if (xfer_fire) begin
        pend_q <= pend_nxt;
      end
    end
  end

  // ports
  assign mem_req_o     = (state_q == ST_XFER);
  assign mem_we_o      = (state_q == ST_XFER) && !teardown_q;
  assign mem_addr_o    = teardown_q ? sp_q : sp_dn;
  assign mem_wdata_o   = rf_rdata_i;
  assign rf_idx_o      = (state_q == ST_FIN) ? jreg_q : cur_reg;
  assign rf_we_o       = xfer_fire && teardown_q;
  assign rf_wdata_o    = mem_rdata_i;
  assign done_o        = (state_q == ST_FIN);
  assign jump_o        = (state_q == ST_FIN) && teardown_q && (jreg_q != '0);
  assign jump_target_o = rf_rdata_i;
  assign sp_o          = sp_q;

  // R2: a completed push leaves the pointer on the word just written
  a_r2_push_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_rdy_i) |=> (sp_o == $past(mem_addr_o)));

  // R4: a completed pop moves the pointer one word above the word read
  a_r4_pop_moves_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o && mem_rdy_i) |=> (sp_o == $past(mem_addr_o) + AW'(WORD_BYTES)));

  // R4: register writes come only from a completed read
  a_r4_write_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_req_o && !mem_we_o && mem_rdy_i));

  // R7: the transfer state always has a selected register to serve
  a_r7_xfer_has_work: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> pick_any);

  // R8: an access waiting for ready keeps address and direction
  a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: a jump request only appears together with completion
  a_r6_jump_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |-> done_o);

  // R10: nothing to do completes on the next cycle with the pointer untouched
  a_r10_empty_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && list_full == '0 && frame_imm_i == '0) |=> (done_o && sp_o == $past(sp_i)));

  // R11: no memory access is issued in the cycle after completion
  a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !mem_req_o);

endmodule

// File: tb/frame_seq_tb.sv
`timescale 1ns/1ps
module frame_seq_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        start, mode, list_hi;
  logic [10:0] list_lo;
  logic [4:0]  imm, jreg;
  logic [31:0] sp_in;
  logic [31:0] sp_out, jtgt;
  logic        done, jump;
  logic        mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [4:0]  rf_idx;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;

  frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
    .list_hi_i(list_hi), .list_lo_i(list_lo), .frame_imm_i(imm), .jreg_i(jreg),
    .sp_i(sp_in), .sp_o(sp_out), .done_o(done), .jump_o(jump),
    .jump_target_o(jtgt), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_rdy_i(mem_rdy), .rf_idx_o(rf_idx), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_wdata_o(rf_wdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // bench models of register bank and memory
  logic [31:0] bank [32];
  logic [31:0] mem  [64];
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic [4:0]  log_idx  [64];
  int          nlog;
  logic        load_bank, log_clr;
  int          pat;
  int          wait_n, wcnt;

  function automatic logic [31:0] val(input int p, input int r);
    return (32'(p) << 8) ^ 32'(r) ^ 32'h5A00_0000;
  endfunction

  assign rf_rdata = bank[rf_idx];

  always @(posedge clk) begin
    if (load_bank)
      for (int r = 0; r < 32; r++) bank[r] <= val(pat, r);
    else if (rf_we)
      bank[rf_idx] <= rf_wdata;
    if (mem_req && mem_we && mem_rdy) mem[mem_addr[7:2]] <= mem_wdata;
    if (log_clr) nlog <= 0;
    else if (mem_req && mem_rdy && nlog < 64) begin
      log_addr[nlog] <= mem_addr;
      log_we[nlog]   <= mem_we;
      log_idx[nlog]  <= rf_idx;
      nlog           <= nlog + 1;
    end
  end

  always @(negedge clk) begin
    if (mem_rdy) wcnt = 0;
    if (mem_req) begin
      if (wcnt >= wait_n) begin
        mem_rdy   = 1'b1;
        mem_rdata = mem[mem_addr[7:2]];
      end else begin
        mem_rdy = 1'b0;
        wcnt++;
      end
    end else begin
      mem_rdy = 1'b0;
      wcnt    = 0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic preload(input int p);
    step(); load_bank = 1'b1; pat = p;
    step(); load_bank = 1'b0;
  endtask

  // runs one sequence, returns latency in cycles and the completion values
  task automatic run_seq(input logic md, input logic [11:0] lst, input logic [4:0] im,
                         input logic [4:0] jr, input logic [31:0] sp0,
                         output int lat, output logic [31:0] spf,
                         output logic jmp, output logic [31:0] tgt);
    step();
    start = 1'b1; mode = md; list_hi = lst[11]; list_lo = lst[10:0];
    imm = im; jreg = jr; sp_in = sp0; log_clr = 1'b1;
    step();
    start = 1'b0; log_clr = 1'b0;
    lat = 1;
    while (!done && lat < 2000) begin
      step();
      lat++;
    end
    spf = sp_out; jmp = jump; tgt = jtgt;
  endtask

  function automatic int popc(input logic [11:0] l);
    int c = 0;
    for (int k = 0; k < 12; k++) c += int'(l[k]);
    return c;
  endfunction

  // full build then teardown for one list; checks order, timing, restore
  task automatic round_trip(input logic [11:0] lst, input logic [4:0] im, input int w);
    int lat, pc, j, scr;
    logic [31:0] sp0, spb, spt, tg;
    logic jp, ok;
    sp0 = 32'h0000_0100;
    pc  = popc(lst);
    wait_n = w;
    preload(int'(lst));
    run_seq(1'b0, lst, im, 5'd7, sp0, lat, spb, jp, tg);
    chk("R8", "build latency", 32'(lat), 32'(1 + int'(im != 0) + pc * (w + 1)));
    chk("R3", "build final sp", spb, sp0 - 32'(4 * (pc + int'(im))));
    chk("R6", "build never jumps", 32'(jp), 32'd0);
    ok = (nlog == pc);
    j = 0;
    for (int k = 0; k < 12; k++) if (lst[k]) begin
      if (log_addr[j] !== sp0 - 32'(4 * (j + 1)) || log_we[j] !== 1'b1 ||
          log_idx[j] !== 5'(20 + k) || mem[log_addr[j][7:2]] !== val(int'(lst), 20 + k))
        ok = 1'b0;
      j++;
    end
    chk("R2", "ascending pushes", 32'(ok), 32'd1);
    scr = int'(lst) ^ 32'h0003_0F0F;
    preload(scr);
    run_seq(1'b1, lst, im, 5'd0, spb, lat, spt, jp, tg);
    chk("R8", "teardown latency", 32'(lat), 32'(1 + int'(im != 0) + pc * (w + 1)));
    chk("R5", "teardown final sp", spt, sp0);
    chk("R6", "zero field no jump", 32'(jp), 32'd0);
    ok = (nlog == pc);
    j = 0;
    for (int k = 11; k >= 0; k--) if (lst[k]) begin
      if (log_addr[j] !== spb + 32'(4 * int'(im)) + 32'(4 * j) || log_we[j] !== 1'b0 ||
          log_idx[j] !== 5'(20 + k))
        ok = 1'b0;
      j++;
    end
    chk("R4", "descending pops", 32'(ok), 32'd1);
    ok = 1'b1;
    for (int k = 0; k < 12; k++) begin
      if (lst[k]  && bank[20 + k] !== val(int'(lst), 20 + k)) ok = 1'b0;
      if (!lst[k] && bank[20 + k] !== val(scr, 20 + k))       ok = 1'b0;
    end
    chk("R5", "restore selected, R7 untouched others", 32'(ok), 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] spf, tg;
    logic jp;
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; list_hi = 1'b0; list_lo = '0;
    imm = '0; jreg = '0; sp_in = '0; load_bank = 1'b0; log_clr = 1'b0;
    pat = 0; wait_n = 0; wcnt = 0; mem_rdy = 1'b0; mem_rdata = '0; nlog = 0;
    for (int a = 0; a < 64; a++) mem[a] = '0;
    for (int r = 0; r < 32; r++) bank[r] = '0;
    repeat (3) step();
    chk("R12", "reset done", 32'(done), 32'd0);
    chk("R12", "reset jump", 32'(jump), 32'd0);
    chk("R12", "reset mem_req", 32'(mem_req), 32'd0);
    chk("R12", "reset rf_we", 32'(rf_we), 32'd0);
    rst_n = 1'b1;
    step();

    // R10: nothing to do, both modes
    run_seq(1'b0, 12'h000, 5'd0, 5'd0, 32'h1234_5670, lat, spf, jp, tg);
    chk("R10", "empty build latency", 32'(lat), 32'd1);
    chk("R10", "empty build sp", spf, 32'h1234_5670);
    run_seq(1'b1, 12'h000, 5'd0, 5'd0, 32'h0000_0ABC, lat, spf, jp, tg);
    chk("R10", "empty teardown latency", 32'(lat), 32'd1);
    chk("R10", "empty teardown sp", spf, 32'h0000_0ABC);
    step();
    chk("R9", "done is one cycle", 32'(done), 32'd0);

    // R1: only the top list bit selects register 31
    wait_n = 0;
    preload(77);
    run_seq(1'b0, 12'h800, 5'd0, 5'd0, 32'h0000_0100, lat, spf, jp, tg);
    chk("R1", "top bit register", 32'(log_idx[0]), 32'd31);
    chk("R1", "top bit data", mem[6'h3F], val(77, 31));
    run_seq(1'b0, 12'h001, 5'd0, 5'd0, 32'h0000_0100, lat, spf, jp, tg);
    chk("R1", "bottom bit register", 32'(log_idx[0]), 32'd20);

    // R8: wait states
    round_trip(12'h0A5, 5'd3, 2);

    // R11: start pulse while busy
    wait_n = 3;
    preload(500);
    fork
      run_seq(1'b0, 12'h3C1, 5'd2, 5'd0, 32'h0000_0100, lat, spf, jp, tg);
      begin
        repeat (5) step();
        start = 1'b1; mode = 1'b1; list_hi = 1'b0; list_lo = 11'h7FF; imm = 5'd9;
        step();
        start = 1'b0;
      end
    join
    chk("R11", "busy start latency", 32'(lat), 32'(1 + 1 + 5 * 4));
    chk("R11", "busy start sp", spf, 32'h0000_0100 - 32'(4 * (5 + 2)));
    step();
    chk("R11", "no second sequence", 32'(done | mem_req), 32'd0);

    // R6: jump targets
    wait_n = 0;
    preload(600);
    run_seq(1'b0, 12'h030, 5'd1, 5'd0, 32'h0000_0100, lat, spf, jp, tg);
    preload(601);
    run_seq(1'b1, 12'h030, 5'd1, 5'd25, spf, lat, spf, jp, tg);
    chk("R6", "jump on restored register", 32'(jp), 32'd1);
    chk("R6", "target after pops", tg, val(600, 25));
    run_seq(1'b1, 12'h000, 5'd0, 5'd3, 32'h0000_0100, lat, spf, jp, tg);
    chk("R6", "jump on low register", 32'(jp), 32'd1);
    chk("R6", "low register target", tg, val(601, 3));

    // full sweep of every list, frame size walking all values
    for (int l = 0; l < 4096; l++)
      round_trip(12'(l), 5'(l % 32), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule